// File: doc/BRIEF.md
# Display control register file

This block sits on the control port of a display engine. Each 32-bit control write carries an opcode in its top byte and a payload in the lower 24 bits. The block decodes the write and keeps the display configuration: the display-disable flag, the transfer direction, the display-area origin, the horizontal and vertical display ranges and the display mode. From the mode bits it derives the horizontal and vertical resolution. From the horizontal range it derives the effective displayed width.

A second, plain input carries drawing-environment words from the drawing command path. Words whose top byte is 0xE0 to 0xE7 are kept in eight environment registers. When the drawing path signals the end of a batch, the draw-mode register (tag 0xE1) and the mask register (tag 0xE6) are packed into the low 13 bits of the status word. The status word is a plain output and is always valid.

The control input uses valid/ready. `ctl_ready` is held high, so the block never applies back-pressure and a word is taken on every clock edge where `ctl_valid` is high. The drawing path and the status outputs have no handshake.

Top module: `disp_ctrl_regs`

## Requirements
- R1: After `rst_n` is released, `status_word` is 0x14802000, `hres` is 256, `vres` is 240, `eff_width` is 256, and the origin and both ranges are zero.
- R2: Control opcode 0x00 returns all state to the R1 values. It also loads environment register k with (0xE0+k)<<24, so a later batch end puts 0 into status bits 12:0. If a batch end falls in the same cycle, opcode 0x00 takes priority.
- R3: Opcode 0x03 writes payload bit 0 into status bit 23, the display-disable flag. No other status bit changes.
- R4: Opcode 0x04 writes payload bits 1:0 into status bits 30:29, the transfer direction.
- R5: Opcode 0x05 sets `origin_x` from payload bits 9:0 and `origin_y` from payload bits 19:10.
- R6: Opcode 0x06 sets `hrange_lo` from bits 11:0 and `hrange_hi` from bits 23:12. Opcode 0x07 sets `vrange_lo` from bits 9:0 and `vrange_hi` from bits 19:10.
- R7: Opcode 0x08 replaces status bits 22:16. Payload bits 5:0 go to status bits 22:17 and payload bit 6 goes to status bit 16.
- R8: `hres` is looked up from status bits 18:16 in the table {256,368,320,384,512,512,640,640}. `vres` is looked up from status bits 20:19 in the table {240,480,256,480}.
- R9: Let span = `hrange_hi` − `hrange_lo`. If 0 < span < 2560, `eff_width` = floor(span·`hres`/2560). Otherwise `eff_width` = `hres`.
- R10: A drawing word with top byte 0xE0+k (k = 0 to 7) stores the whole word in environment register k when `draw_valid` is high. Any other drawing word is ignored.
- R11: On `batch_end`, status bits 10:0 take bits 10:0 of register 0xE1, and status bits 12:11 take bits 1:0 of register 0xE6. The values used are those held before any environment write in the same cycle.
- R12: Opcodes other than 0x00 and 0x03 to 0x08 change nothing. A word with `ctl_valid` low also changes nothing.
- R13: `ctl_ready` is always high. A control write appears on the outputs in the cycle after the edge that takes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted (held high) |
| ctl_data | input | 32 | Control word: opcode in 31:24, payload in 23:0 |
| draw_valid | input | 1 | Drawing-environment word strobe |
| draw_word | input | 32 | Drawing-environment word, tag in 31:24 |
| batch_end | input | 1 | End of drawing batch; folds mode and mask into status |
| status_word | output | 32 | Assembled status word |
| origin_x | output | 10 | Display origin x |
| origin_y | output | 10 | Display origin y |
| hrange_lo | output | 12 | Horizontal range start |
| hrange_hi | output | 12 | Horizontal range end |
| vrange_lo | output | 10 | Vertical range start |
| vrange_hi | output | 10 | Vertical range end |
| hres | output | 10 | Horizontal resolution |
| vres | output | 9 | Vertical resolution |
| eff_width | output | 10 | Effective displayed width |

## Verification
A display-mode write on the control port and a batch end from the drawing path can land on the same edge. Both update the status word, but they touch different bit fields. The bench drives both in one cycle and expects bits 22:16 to come from the mode payload and bits 12:0 from the environment registers at once. In a related case, a batch end arrives in the same cycle as a new 0xE1 environment word. The bench checks that the fold uses the older register value, and that the new value shows up only at the following batch end.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam logic [31:0] STATUS_RST = 32'h1480_2000;

  localparam logic [7:0] OP_FULL_RESET = 8'h00;
  localparam logic [7:0] OP_BLANK      = 8'h03;
  localparam logic [7:0] OP_DIR        = 8'h04;
  localparam logic [7:0] OP_ORIGIN     = 8'h05;
  localparam logic [7:0] OP_HRANGE     = 8'h06;
  localparam logic [7:0] OP_VRANGE     = 8'h07;
  localparam logic [7:0] OP_MODE       = 8'h08;

  localparam int ST_BLANK_BIT = 23;
  localparam int ST_DIR_LO    = 29;
  localparam int ST_MODE_LO   = 16;
  localparam int ST_MODE_W    = 7;
  localparam int ST_FOLD_W    = 13;

  typedef struct packed {
    logic full_reset;
    logic blank;
    logic dir;
    logic origin;
    logic hrange;
    logic vrange;
    logic mode;
  } ctl_strobe_t;

  function automatic logic [9:0] hres_of(input logic [2:0] idx);
    case (idx)
      3'd0:    return 10'd256;
      3'd1:    return 10'd368;
      3'd2:    return 10'd320;
      3'd3:    return 10'd384;
      3'd4,
      3'd5:    return 10'd512;
      default: return 10'd640;
    endcase
  endfunction

  function automatic logic [8:0] vres_of(input logic [1:0] idx);
    case (idx)
      2'd0:    return 9'd240;
      2'd2:    return 9'd256;
      default: return 9'd480;
    endcase
  endfunction

endpackage

// File: rtl/dcr_cmd_decode.sv
module dcr_cmd_decode
  import dcr_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] word,
  output ctl_strobe_t strobe
);
  logic [7:0] opcode;
  assign opcode = word[31:24];

  always_comb begin
    strobe = '0;
    if (valid) begin
      case (opcode)
        OP_FULL_RESET: strobe.full_reset = 1'b1;
        OP_BLANK:      strobe.blank      = 1'b1;
        OP_DIR:        strobe.dir        = 1'b1;
        OP_ORIGIN:     strobe.origin     = 1'b1;
        OP_HRANGE:     strobe.hrange     = 1'b1;
        OP_VRANGE:     strobe.vrange     = 1'b1;
        OP_MODE:       strobe.mode       = 1'b1;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/dcr_env_bank.sv
module dcr_env_bank #(
  parameter int          N_ENV    = 8,
  parameter logic [7:0]  TAG_BASE = 8'hE0,
  parameter int          MODE_IDX = 1,
  parameter int          MASK_IDX = 6,
  parameter int          MODE_W   = 11,
  parameter int          MASK_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [31:0]       wr_word,
  output logic [MODE_W-1:0] draw_mode,
  output logic [MASK_W-1:0] mask_bits
);
  logic [31:0] env_q [N_ENV];

  for (genvar k = 0; k < N_ENV; k++) begin : g_env
    localparam logic [7:0] TAG = 8'(int'(TAG_BASE) + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        env_q[k] <= {TAG, 24'h0};
      else if (clr)
        env_q[k] <= {TAG, 24'h0};
      else if (wr_valid && wr_word[31:24] == TAG)
        env_q[k] <= wr_word;
    end
  end

  assign draw_mode = env_q[MODE_IDX][MODE_W-1:0];
  assign mask_bits = env_q[MASK_IDX][MASK_W-1:0];
endmodule

// File: rtl/dcr_res_calc.sv
module dcr_res_calc
  import dcr_pkg::*;
#(
  parameter int SPAN_W    = 12,
  parameter int RES_W     = 10,
  parameter int VRES_W    = 9,
  parameter int SPAN_FULL = 2560
) (
  input  logic [ST_MODE_W-1:0] mode_field,
  input  logic [SPAN_W-1:0]    x_lo,
  input  logic [SPAN_W-1:0]    x_hi,
  output logic [RES_W-1:0]     hres,
  output logic [VRES_W-1:0]    vres,
  output logic [RES_W-1:0]     eff_width
);
  localparam int PROD_W = SPAN_W + RES_W;

  logic signed [SPAN_W:0] span;
  logic                   not_positive;
  logic                   too_wide;
  logic [PROD_W-1:0]      prod;
  logic [PROD_W-1:0]      quot;

  // mode_field[2:0] is status 18:16, mode_field[4:3] is status 20:19
  assign hres = RES_W'(hres_of(mode_field[2:0]));
  assign vres = VRES_W'(vres_of(mode_field[4:3]));

  assign span         = $signed({1'b0, x_hi}) - $signed({1'b0, x_lo});
  assign not_positive = span[SPAN_W] || (span == '0);
  assign too_wide     = !span[SPAN_W] &&
                        (span[SPAN_W-1:0] >= SPAN_W'(SPAN_FULL));
  assign prod         = PROD_W'(span[SPAN_W-1:0]) * PROD_W'(hres);
  assign quot         = prod / PROD_W'(SPAN_FULL);

  always_comb begin
    if (not_positive || too_wide)
      eff_width = hres;
    else
      eff_width = quot[RES_W-1:0];
  end
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import dcr_pkg::*;
#(
  parameter int ORG_W     = 10,
  parameter int HR_W      = 12,
  parameter int VR_W      = 10,
  parameter int RES_W     = 10,
  parameter int VRES_W    = 9,
  parameter int N_ENV     = 8,
  parameter int SPAN_FULL = 2560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  input  logic [31:0]       ctl_data,
  input  logic              draw_valid,
  input  logic [31:0]       draw_word,
  input  logic              batch_end,
  output logic [31:0]       status_word,
  output logic [ORG_W-1:0]  origin_x,
  output logic [ORG_W-1:0]  origin_y,
  output logic [HR_W-1:0]   hrange_lo,
  output logic [HR_W-1:0]   hrange_hi,
  output logic [VR_W-1:0]   vrange_lo,
  output logic [VR_W-1:0]   vrange_hi,
  output logic [RES_W-1:0]  hres,
  output logic [VRES_W-1:0] vres,
  output logic [RES_W-1:0]  eff_width
);
  localparam int MODE_W = 11;
  localparam int MASK_W = ST_FOLD_W - MODE_W;

  ctl_strobe_t       st;
  logic [MODE_W-1:0] env_mode;
  logic [MASK_W-1:0] env_mask;
  logic [31:0]       status_q;

  assign ctl_ready = 1'b1;

  dcr_cmd_decode u_dec (
    .valid  (ctl_valid),
    .word   (ctl_data),
    .strobe (st)
  );

  dcr_env_bank #(
    .N_ENV  (N_ENV),
    .MODE_W (MODE_W),
    .MASK_W (MASK_W)
  ) u_env (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (st.full_reset),
    .wr_valid  (draw_valid),
    .wr_word   (draw_word),
    .draw_mode (env_mode),
    .mask_bits (env_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
    end else if (st.full_reset) begin
      status_q <= STATUS_RST;
    end else begin
      if (batch_end)
        status_q[ST_FOLD_W-1:0] <= {env_mask, env_mode};
      if (st.blank)
        status_q[ST_BLANK_BIT] <= ctl_data[0];
      if (st.dir)
        status_q[ST_DIR_LO +: 2] <= ctl_data[1:0];
      if (st.mode)
        status_q[ST_MODE_LO +: ST_MODE_W] <= {ctl_data[5:0], ctl_data[6]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin_x  <= '0;
      origin_y  <= '0;
      hrange_lo <= '0;
      hrange_hi <= '0;
      vrange_lo <= '0;
      vrange_hi <= '0;
    end else if (st.full_reset) begin
      origin_x  <= '0;
      origin_y  <= '0;
      hrange_lo <= '0;
      hrange_hi <= '0;
      vrange_lo <= '0;
      vrange_hi <= '0;
    end else begin
      if (st.origin) begin
        origin_x <= ctl_data[ORG_W-1:0];
        origin_y <= ctl_data[ORG_W +: ORG_W];
      end
      if (st.hrange) begin
        hrange_lo <= ctl_data[HR_W-1:0];
        hrange_hi <= ctl_data[HR_W +: HR_W];
      end
      if (st.vrange) begin
        vrange_lo <= ctl_data[VR_W-1:0];
        vrange_hi <= ctl_data[VR_W +: VR_W];
      end
    end
  end

  assign status_word = status_q;

  dcr_res_calc #(
    .SPAN_W    (HR_W),
    .RES_W     (RES_W),
    .VRES_W    (VRES_W),
    .SPAN_FULL (SPAN_FULL)
  ) u_res (
    .mode_field (status_q[ST_MODE_LO +: ST_MODE_W]),
    .x_lo       (hrange_lo),
    .x_hi       (hrange_hi),
    .hres       (hres),
    .vres       (vres),
    .eff_width  (eff_width)
  );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_valid,
  input logic [31:0] ctl_data,
  input logic        batch_end,
  input logic [31:0] status_word,
  input logic [9:0]  origin_x,
  input logic [9:0]  origin_y,
  input logic [9:0]  hres,
  input logic [9:0]  eff_width
);
  logic [7:0] op;
  logic       known;
  assign op    = ctl_data[31:24];
  assign known = (op == 8'h00) || (op >= 8'h03 && op <= 8'h08);

  p_reset_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && op == 8'h00) |=> (status_word == 32'h1480_2000));

  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && op == 8'h03) |=> (status_word[23] == $past(ctl_data[0])));

  p_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && op == 8'h04) |=> (status_word[30:29] == $past(ctl_data[1:0])));

  p_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && op == 8'h05) |=>
      (origin_x == $past(ctl_data[9:0]) && origin_y == $past(ctl_data[19:10])));

  p_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && op == 8'h08) |=>
      (status_word[22:16] == {$past(ctl_data[5:0]), $past(ctl_data[6])}));

  p_fold_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!batch_end && !(ctl_valid && op == 8'h00)) |=> $stable(status_word[12:0]));

  p_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctl_valid || !known) && !batch_end) |=> $stable(status_word));

  always_ff @(posedge clk) begin
    if (rst_n) begin
      p_width_r9: assert (eff_width <= hres);
    end
  end
endmodule

bind disp_ctrl_regs dcr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_valid   (ctl_valid),
  .ctl_data    (ctl_data),
  .batch_end   (batch_end),
  .status_word (status_word),
  .origin_x    (origin_x),
  .origin_y    (origin_y),
  .hres        (hres),
  .eff_width   (eff_width)
);

// File: tb/sim_disp_ctrl_regs.sv
`timescale 1ns/1ps
module sim_disp_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0;
  logic        ctl_ready;
  logic [31:0] ctl_data = '0;
  logic        draw_valid = 1'b0;
  logic [31:0] draw_word = '0;
  logic        batch_end = 1'b0;
  logic [31:0] status_word;
  logic [9:0]  origin_x, origin_y, vrange_lo, vrange_hi, hres, eff_width;
  logic [11:0] hrange_lo, hrange_hi;
  logic [8:0]  vres;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  disp_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_data(ctl_data), .draw_valid(draw_valid), .draw_word(draw_word),
    .batch_end(batch_end), .status_word(status_word), .origin_x(origin_x),
    .origin_y(origin_y), .hrange_lo(hrange_lo), .hrange_hi(hrange_hi),
    .vrange_lo(vrange_lo), .vrange_hi(vrange_hi), .hres(hres), .vres(vres),
    .eff_width(eff_width)
  );

  // {control word, status, hres, vres, eff_width}
  localparam int NV = 14;
  localparam logic [92:0] VEC [NV] = '{
    {32'h0300_0000, 32'h1400_2000, 10'd256, 9'd240, 10'd256},
    {32'h0400_0002, 32'h5400_2000, 10'd256, 9'd240, 10'd256},
    {32'h0800_0001, 32'h5402_2000, 10'd320, 9'd240, 10'd320},
    {32'h06C6_0260, 32'h5402_2000, 10'd320, 9'd240, 10'd320},
    {32'h0676_0260, 32'h5402_2000, 10'd320, 9'd240, 10'd160},
    {32'h0800_0047, 32'h540F_2000, 10'd640, 9'd480, 10'd320},
    {32'h0626_0760, 32'h540F_2000, 10'd640, 9'd480, 10'd640},
    {32'h0600_1000, 32'h540F_2000, 10'd640, 9'd480, 10'd0},
    {32'h069F_F000, 32'h540F_2000, 10'd640, 9'd480, 10'd639},
    {32'h0900_0000, 32'h540F_2000, 10'd640, 9'd480, 10'd639},
    {32'h0800_0008, 32'h5410_2000, 10'd256, 9'd256, 10'd255},
    {32'h0400_0001, 32'h3410_2000, 10'd256, 9'd256, 10'd255},
    {32'h0300_0001, 32'h3490_2000, 10'd256, 9'd256, 10'd255},
    {32'h0800_000C, 32'h3498_2000, 10'd256, 9'd480, 10'd255}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic cyc(input logic cv, input logic [31:0] cw,
                     input logic dv, input logic [31:0] dw, input logic be);
    @(negedge clk);
    ctl_valid = cv; ctl_data = cw; draw_valid = dv; draw_word = dw; batch_end = be;
    @(negedge clk);
    ctl_valid = 1'b0; draw_valid = 1'b0; batch_end = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_word, 32'h1480_2000);
    chk("R1 hres", 32'(hres), 32'd256);
    chk("R1 vres", 32'(vres), 32'd240);
    chk("R1 eff_width", 32'(eff_width), 32'd256);
    chk("R1 origin", {12'h0, origin_y, origin_x}, 32'h0);
    chk("R13 ready", 32'(ctl_ready), 32'd1);

    // R13: not visible before the taking edge
    @(negedge clk);
    ctl_valid = 1'b1; ctl_data = 32'h0300_0000;
    #1;
    chk("R13 before edge", status_word, 32'h1480_2000);
    ctl_valid = 1'b0;

    // table walk: R3 R4 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i][92:61], 1'b0, 32'h0, 1'b0);
      chk("R3 R4 R7 R12 status", status_word, VEC[i][60:29]);
      chk("R8 hres", 32'(hres), 32'(VEC[i][28:19]));
      chk("R8 vres", 32'(vres), 32'(VEC[i][18:10]));
      chk("R9 eff_width", 32'(eff_width), 32'(VEC[i][9:0]));
    end
    chk("R6 hrange_lo", 32'(hrange_lo), 32'h0);
    chk("R6 hrange_hi", 32'(hrange_hi), 32'h9FF);

    // R12: valid low ignored
    cyc(1'b0, 32'h0300_0000, 1'b0, 32'h0, 1'b0);
    chk("R12 valid low", status_word, 32'h3498_2000);

    // R5 origin, R6 vertical range
    cyc(1'b1, 32'h0505_57FF, 1'b0, 32'h0, 1'b0);
    chk("R5 origin_x", 32'(origin_x), 32'h3FF);
    chk("R5 origin_y", 32'(origin_y), 32'h155);
    cyc(1'b1, 32'h0708_0010, 1'b0, 32'h0, 1'b0);
    chk("R6 vrange_lo", 32'(vrange_lo), 32'h010);
    chk("R6 vrange_hi", 32'(vrange_hi), 32'h200);

    // R10 R11 environment capture and fold
    cyc(1'b0, 32'h0, 1'b1, 32'hE100_07FF, 1'b0);
    cyc(1'b0, 32'h0, 1'b1, 32'hE600_0003, 1'b0);
    chk("R11 no fold yet", status_word, 32'h3498_2000);
    cyc(1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    chk("R11 fold", status_word, 32'h3498_3FFF);
    cyc(1'b0, 32'h0, 1'b1, 32'h2C00_0AAA, 1'b1);
    chk("R10 non-env ignored", status_word, 32'h3498_3FFF);
    cyc(1'b0, 32'h0, 1'b1, 32'hE100_0005, 1'b1);
    chk("R11 fold uses old E1", status_word, 32'h3498_3FFF);
    cyc(1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    chk("R11 fold new E1", status_word, 32'h3498_3805);

    // mode write and fold on the same edge: R7 R11
    cyc(1'b1, 32'h0800_0001, 1'b1, 32'hE100_0011, 1'b1);
    chk("R7 R11 same cycle", status_word, 32'h3482_3805);
    chk("R8 hres same cycle", 32'(hres), 32'd320);

    // R2 reset command with concurrent batch end
    cyc(1'b1, 32'h0000_0000, 1'b0, 32'h0, 1'b1);
    chk("R2 status", status_word, 32'h1480_2000);
    chk("R2 hres", 32'(hres), 32'd256);
    chk("R2 eff_width", 32'(eff_width), 32'd256);
    chk("R2 origin", {12'h0, origin_y, origin_x}, 32'h0);
    chk("R2 ranges", {vrange_hi[3:0], hrange_hi, hrange_lo, vrange_lo[3:0]}, 32'h0);
    cyc(1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    chk("R2 env defaults fold", status_word, 32'h1480_2000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule